// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block takes one character at a time from a valid/ready holding input and shifts it out onto a single transmit line. It is paced by a baud tick input that pulses once per sixteenth of a bit period. The frame format comes from a seven-bit line-control input, which sets the character length, the stop-bit length and the parity scheme. The block reads that format when a character is accepted and keeps it until the character is finished.

A frame is a start bit at 0, then the data bits with the least significant first, then an optional parity bit, then the stop bits at 1. The line rests at 1 between frames. A break request in the control input forces the line low for as long as it is set. The frame keeps its timing underneath the break, so the line returns to the normal waveform as soon as the request is cleared. A surrounding design supplies the baud tick and the control byte, and it feeds characters whenever `char_ready` is high.

Top module: `serial_frame_tx`

## Requirements
- R1: The number of data bits is 5 + line_ctrl[1:0] (00→5, 01→6, 10→7, 11→8). The data bits follow a single start bit at 0, with char_data[0] sent first.
- R2: The start, data and parity bits each last 16 baud ticks. tx_out changes only in the clock cycle that follows a cycle in which baud_tick was high, unless the break request changes.
- R3: With line_ctrl[2] at 0, the frame ends with one stop bit at 1 lasting 16 ticks, whatever the character length.
- R4: With line_ctrl[2] at 1, the stop period lasts 24 ticks (1.5 bits) for a 5-bit character and 32 ticks (2 bits) for a 6-, 7- or 8-bit character.
- R5: With line_ctrl[3] at 0, no parity bit is sent, and the stop period follows the last data bit directly.
- R6: With line_ctrl[3] at 1 and line_ctrl[5] at 0, a parity bit follows the data. line_ctrl[4] at 0 makes the count of 1s over the data and parity odd. line_ctrl[4] at 1 makes that count even.
- R7: With line_ctrl[3] at 1 and line_ctrl[5] at 1, the parity bit is fixed at 1 when line_ctrl[4] is 0 and at 0 when line_ctrl[4] is 1.
- R8: While line_ctrl[6] is 1, tx_out is 0 from the next sample on, both when idle and during a frame. The frame timing and the end of busy are unchanged.
- R9: After reset, tx_out is 1, busy is 0 and char_ready is 1. A character is taken on a clock edge where char_valid and char_ready are both high, and busy is high from the next cycle on.
- R10: char_ready stays low and busy stays high until the clock edge of the last baud tick of the stop period. From the cycle after that edge, the block is idle again with tx_out at 1 (or 0 under break).
- R11: Changes to line_ctrl[5:0] after a character is accepted have no effect on that frame. The format is taken at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_ctrl | input | 7 | Frame format and break request |
| char_data | input | 8 | Character to send |
| char_valid | input | 1 | char_data holds a character |
| char_ready | output | 1 | Block can take a character |
| busy | output | 1 | A frame is in progress |
| tx_out | output | 1 | Serial transmit line |

## Verification
A wrong state or a wrong bit counter appears on tx_out within one bit period as a bit in the wrong place. Examples are a missing or extra data bit, parity in the wrong slot, or a stop period of the wrong length. A corrupted tick counter shows up at the next bit boundary as a bit of the wrong width. It also shows up at the end of the frame, where busy falls one or more ticks early or late. A format that is not held for the whole frame appears as soon as the control input changes in the middle of a frame. For that reason the bench scrambles the format bits right after every acceptance.

// File: rtl/sftx_pkg.sv
// Package: shared types and control-field positions for the serial frame
// transmitter. Assumes a seven-bit line-control word.
package sftx_pkg;

    localparam int CTRL_W      = 7;
    localparam int F_LEN_LO    = 0;   // two-bit character length field
    localparam int F_STOP_LONG = 2;
    localparam int F_PAR_EN    = 3;
    localparam int F_PAR_SENSE = 4;
    localparam int F_PAR_FORCE = 5;
    localparam int F_BREAK     = 6;
    localparam int LEN_W       = 4;   // holds up to 15 data bits
    localparam int TICKS_W     = 8;   // holds up to 255 ticks per bit slot

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    typedef struct packed {
        logic [LEN_W-1:0]   data_bits;
        logic               par_en;
        logic               par_val;
        logic [TICKS_W-1:0] stop_ticks;
    } frame_cfg_t;

endpackage

// File: rtl/sftx_parity_gen.sv
// Module: computes the parity bit for a character of variable length.
// Assumes the bits above data_bits are ignored. The sense and force inputs
// follow the line-control encoding.
module sftx_parity_gen #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  data_bits,
    input  logic              sense_even,
    input  logic              force_fixed,
    output logic              parity
);
    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    // Mask off the bits beyond the programmed character length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (LEN_W'(i) < data_bits);
    end

    assign ones_odd = ^masked;

    // Choose between the computed parity and the fixed mark/space value.
    always_comb begin
        if (force_fixed)
            parity = ~sense_even;
        else if (sense_even)
            parity = ones_odd;
        else
            parity = ~ones_odd;
    end

endmodule

// File: rtl/sftx_fmt_decode.sv
// Module: turns the line-control word and the character into a frame
// configuration. Purely combinational; the sequencer samples it at
// acceptance.
module sftx_fmt_decode
    import sftx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int MIN_BITS      = 5,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic [5:0]        fmt,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg
);
    localparam logic [TICKS_W-1:0] ONE_STOP  = TICKS_W'(TICKS_PER_BIT);
    localparam logic [TICKS_W-1:0] HALF_STOP = TICKS_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [TICKS_W-1:0] TWO_STOP  = TICKS_W'(2 * TICKS_PER_BIT);

    logic [1:0]       len_code;
    logic [LEN_W-1:0] n_bits;
    logic             par_bit;

    assign len_code = fmt[F_LEN_LO +: 2];
    assign n_bits   = LEN_W'(MIN_BITS) + LEN_W'(len_code);

    sftx_parity_gen #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_par (
        .data        (data),
        .data_bits   (n_bits),
        .sense_even  (fmt[F_PAR_SENSE]),
        .force_fixed (fmt[F_PAR_FORCE]),
        .parity      (par_bit)
    );

    // Assemble the configuration; the stop length depends on the character length.
    always_comb begin
        cfg.data_bits = n_bits;
        cfg.par_en    = fmt[F_PAR_EN];
        cfg.par_val   = par_bit;
        if (!fmt[F_STOP_LONG])
            cfg.stop_ticks = ONE_STOP;
        else if (len_code == 2'b00)
            cfg.stop_ticks = HALF_STOP;
        else
            cfg.stop_ticks = TWO_STOP;
    end

endmodule

// File: rtl/sftx_tick_timer.sv
// Module: counts baud ticks inside one bit slot and flags the last tick.
// Assumes limit is at least 1 and stays stable while run is high.
module sftx_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             slot_done
);
    logic [CNT_W-1:0] cnt;

    assign slot_done = run && tick && (cnt == limit - 1'b1);

    // Advance on each tick; restart at a slot boundary or a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || slot_done)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sftx_frame_seq.sv
// Module: frame sequencer. Holds the character and its format, and walks
// through the start, data, parity and stop slots. Assumes slot_done comes
// from a timer driven by slot_limit.
module sftx_frame_seq
    import sftx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [DATA_W-1:0]  data_in,
    input  frame_cfg_t         cfg_in,
    input  logic               slot_done,
    output tx_state_t          state,
    output logic               line_bit,
    output logic [TICKS_W-1:0] slot_limit
);
    localparam int BIT_CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0]    shreg;
    frame_cfg_t           cfg_q;
    logic [BIT_CNT_W-1:0] bit_idx;
    logic                 last_data;

    assign last_data = (LEN_W'(bit_idx) == cfg_q.data_bits - 1'b1);

    // State transitions and data shifting at slot boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            cfg_q   <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    shreg   <= data_in;
                    cfg_q   <= cfg_in;
                    bit_idx <= '0;
                    state   <= ST_START;
                end
                ST_START: if (slot_done) state <= ST_DATA;
                ST_DATA: if (slot_done) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (last_data)
                        state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: if (slot_done) state <= ST_STOP;
                ST_STOP:   if (slot_done) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Line level for the current slot, before any break override.
    always_comb begin
        case (state)
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = cfg_q.par_val;
            default:   line_bit = 1'b1;
        endcase
    end

    // Slot length: a full bit, except the stop period.
    assign slot_limit = (state == ST_STOP) ? cfg_q.stop_ticks : TICKS_W'(TICKS_PER_BIT);

endmodule

// File: rtl/serial_frame_tx.sv
// Module: configurable serial transmitter top. Accepts one character via
// valid/ready and sends it framed per line_ctrl. Assumes baud_tick is a
// one-cycle pulse at 16x the bit rate (TICKS_PER_BIT).
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int MIN_BITS      = 5,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [CTRL_W-1:0] line_ctrl,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_valid,
    output logic              char_ready,
    output logic              busy,
    output logic              tx_out
);
    frame_cfg_t         cfg_now;
    tx_state_t          state;
    logic               line_bit;
    logic               slot_done;
    logic               accept;
    logic [TICKS_W-1:0] slot_limit;

    assign char_ready = (state == ST_IDLE);
    assign busy       = ~char_ready;
    assign accept     = char_valid && char_ready;

    sftx_fmt_decode #(
        .DATA_W        (DATA_W),
        .MIN_BITS      (MIN_BITS),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_dec (
        .fmt  (line_ctrl[5:0]),
        .data (char_data),
        .cfg  (cfg_now)
    );

    sftx_tick_timer #(
        .CNT_W (TICKS_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .run       (busy),
        .clear     (accept),
        .limit     (slot_limit),
        .slot_done (slot_done)
    );

    sftx_frame_seq #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .data_in    (char_data),
        .cfg_in     (cfg_now),
        .slot_done  (slot_done),
        .state      (state),
        .line_bit   (line_bit),
        .slot_limit (slot_limit)
    );

    // Break request overrides the line with a live low level.
    assign tx_out = line_bit & ~line_ctrl[F_BREAK];

endmodule

// File: rtl/sftx_checker.sv
// Module: port-level checker for serial_frame_tx, attached by bind.
module sftx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic [6:0] line_ctrl,
    input logic       char_valid,
    input logic       char_ready,
    input logic       busy,
    input logic       tx_out
);
    // R9: an accepted character makes the block busy on the next cycle.
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && char_ready |=> busy);

    // R9: the idle line rests high unless a break is requested.
    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !line_ctrl[6] |-> tx_out);

    // R1: the first slot of a frame is the start bit at 0.
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_out);

    // R2: within a frame the line moves only after a baud tick.
    p_tick_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(baud_tick) && $stable(line_ctrl[6]) |-> $stable(tx_out));

    // R10: a frame ends only on a baud tick.
    p_end_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));

    // R8: a break request holds the line low.
    p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !tx_out);
endmodule

bind serial_frame_tx sftx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .line_ctrl  (line_ctrl),
    .char_valid (char_valid),
    .char_ready (char_ready),
    .busy       (busy),
    .tx_out     (tx_out)
);

// File: tb/serial_frame_tx_tb_top.sv
// Bench: directed sweep of every format plus seeded random frames, each
// compared tick by tick against a model built from the requirements.
module serial_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [6:0] line_ctrl = '0;
    logic [7:0] char_data = '0;
    logic       char_valid = 1'b0;
    logic       char_ready, busy, tx_out;
    int         total = 0;
    int         bad = 0;
    int         div = 0;

    always #4 clk = ~clk;

    // Baud tick: one pulse every four clocks, driven on the falling edge.
    always @(negedge clk) begin
        div = (div + 1) % 4;
        baud_tick <= (div == 0);
    end

    serial_frame_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .line_ctrl  (line_ctrl),
        .char_data  (char_data),
        .char_valid (char_valid),
        .char_ready (char_ready),
        .busy       (busy),
        .tx_out     (tx_out)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int n_bits(input logic [6:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int frame_ticks(input logic [6:0] c);
        int stop = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
        return 16 * (1 + n_bits(c) + int'(c[3])) + stop;
    endfunction

    function automatic logic model_parity(input logic [7:0] d, input logic [6:0] c);
        logic ones = 1'b0;
        for (int i = 0; i < n_bits(c); i++) ones ^= d[i];
        if (c[5]) return ~c[4];
        return c[4] ? ones : ~ones;
    endfunction

    function automatic logic model_tx(input logic [7:0] d, input logic [6:0] c, input int k);
        int seg = k / 16;
        if (c[6]) return 1'b0;
        if (seg == 0) return 1'b0;
        if (seg <= n_bits(c)) return d[seg-1];
        if (c[3] && seg == n_bits(c) + 1) return model_parity(d, c);
        return 1'b1;
    endfunction

    function automatic string req_of(input logic [6:0] c, input int k);
        int seg = k / 16;
        if (c[6]) return "R8";
        if (seg <= n_bits(c)) return "R1";
        if (seg == n_bits(c) + 1) begin
            if (!c[3]) return "R5";
            return c[5] ? "R7" : "R6";
        end
        return c[2] ? "R4" : "R3";
    endfunction

    // Send one frame; alt replaces line_ctrl right after acceptance (R11).
    task automatic send(input logic [7:0] d, input logic [6:0] c, input logic [6:0] alt);
        int    k = 0;
        int    len = frame_ticks(c);
        int    errs = 0;
        int    first_k = -1;
        logic  first_a = 1'b0;
        string tag;
        while (!char_ready) step();
        char_data  = d;
        line_ctrl  = c;
        char_valid = 1'b1;
        step();
        char_valid = 1'b0;
        line_ctrl  = alt;
        check("R9 busy after accept", busy, 1'b1);
        while (k < len) begin
            if (baud_tick) begin
                if (tx_out !== model_tx(d, c, k)) begin
                    if (errs == 0) begin
                        first_k = k;
                        first_a = tx_out;
                    end
                    errs++;
                end
                if (k == len - 1) check("R10 still busy at last stop tick", busy, 1'b1);
                k++;
            end
            step();
        end
        tag = req_of(c, (first_k < 0) ? 0 : first_k);
        if (alt[5:0] != c[5:0]) tag = {tag, " R11"};
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s R2: tick %0d actual=%b expected=%b (d=%h c=%h)",
                     tag, first_k, first_a, model_tx(d, c, first_k), d, c);
        end
        check("R10 idle after stop", busy, 1'b0);
        check("R10 ready after stop", char_ready, 1'b1);
        check("R9 line level after frame", tx_out, ~alt[6]);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [6:0] c, a;
        void'($urandom(32'd20240611));
        repeat (5) step();
        rst_n = 1'b1;
        step();
        check("R9 reset tx", tx_out, 1'b1);
        check("R9 reset busy", busy, 1'b0);
        check("R9 reset ready", char_ready, 1'b1);

        // Break while idle, then release.
        line_ctrl = 7'h40;
        step();
        check("R8 idle break", tx_out, 1'b0);
        line_ctrl = 7'h00;
        step();
        check("R9 idle after break", tx_out, 1'b1);

        // Every format with data patterns that exercise the parity corners.
        for (int i = 0; i < 64; i++) begin
            d = (i % 3 == 0) ? 8'h00 : (i % 3 == 1) ? 8'hFF : 8'h96;
            send(d, 7'(i), 7'(i));
        end

        // Break held during a whole frame.
        send(8'h55, 7'h4B, 7'h4B);

        // Random frames with format scrambled mid-frame.
        for (int n = 0; n < 50; n++) begin
            d    = 8'($urandom);
            c    = 7'($urandom);
            c[6] = ($urandom % 8 == 0);
            a    = {c[6], 6'($urandom)};
            send(d, c, a);
            line_ctrl = {c[6], 6'h00};
            repeat ($urandom % 3) step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule